// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment:offset pair into the physical address a processor core drives while it runs in real mode. It takes the four segment register values (code, stack, data, extra), a 16-bit offset and a code naming the register that produced the offset. From these it picks the segment for the access. A memory operand normally takes its segment from that base register. The caller can supply a one-access override that names a segment outright. An instruction fetch always uses the code segment.

The block keeps its own fetch pointer, a code segment and instruction pointer pair. A synchronous reset loads this pair with F000h:FFF0h, so the first fetch after reset lands at FFFF0h. A far transfer reloads the pair from the code-segment and offset inputs.

The address and the chosen segment are combinational. The sum is 21 bits wide. When the address-line-20 gate is closed, bit 20 is forced low so the address wraps inside the first megabyte. All lines above bit 20 are always zero.

Top module: `rmAddrGen`

## Requirements
- R1: For a data access, physAddr equals segment value × 16 plus the zero-extended offset, on a 32-bit output.
- R2: When fetch is 1, the address is built from the held fetch pointer: held code segment × 16 plus held instruction pointer. segUsed is 1 (code). ovrEn, ovrSel, baseSel and the offset input have no effect on that result.
- R3: For a data access with no override, base codes 4 (stack pointer) and 5 (base pointer) select the stack segment, and segUsed is 2.
- R4: For a data access with no override, base codes 0, 1, 2, 3, 6 and 7 select the data segment, and segUsed is 3.
- R5: For a data access with ovrEn at 1, the segment named by ovrSel is used in place of the default. The segment encoding is 0 extra, 1 code, 2 stack, 3 data, and segUsed reports the same code.
- R6: While rst is high at a rising edge, the fetch pointer is loaded with F000h:FFF0h, so a fetch then gives FFFF0h. Reset takes priority over ptrLoad.
- R7: When ptrLoad is 1 at a rising edge out of reset, codeSeg and offset are copied into the fetch pointer. Fetches use the new pair from the next cycle on.
- R8: With a20Gate at 0, bit 20 of physAddr is 0 even when the sum carries into it. Example: F400:E000 gives 002000h.
- R9: With a20Gate at 1, bit 20 carries the unmasked sum. Example: F400:E000 gives 102000h.
- R10: physAddr bits 31 to 21 are always 0.
- R11: physAddr and segUsed follow their inputs within the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fetch pointer |
| rst | input | 1 | Synchronous reset, active high |
| codeSeg | input | 16 | Code segment value |
| dataSeg | input | 16 | Data segment value |
| stackSeg | input | 16 | Stack segment value |
| extraSeg | input | 16 | Extra segment value |
| offset | input | 16 | Access offset; new instruction pointer when ptrLoad is 1 |
| baseSel | input | 3 | Register that produced the offset (4 stack ptr, 5 base ptr) |
| ovrEn | input | 1 | Segment override for this access |
| ovrSel | input | 2 | Override segment: 0 extra, 1 code, 2 stack, 3 data |
| fetch | input | 1 | Access is an instruction fetch |
| ptrLoad | input | 1 | Load fetch pointer from codeSeg and offset |
| a20Gate | input | 1 | 1 lets bit 20 carry; 0 wraps at 1 MB |
| physAddr | output | 32 | Physical address |
| segUsed | output | 2 | Segment chosen for the access |

## Verification
The address and segment outputs are combinational, so they are due in the same cycle their inputs change. The held fetch pointer changes only at a rising edge, so a load or reset shows up on fetch addresses one edge later. The bench drives inputs 1 ns after each rising edge. Its behavioural model updates its copy of the pointer on the rising edge and compares both outputs at every falling edge, which places each check in the cycle the result is due. One extra check changes the offset in the middle of a cycle and samples shortly after, with no edge between.

// File: rtl/rmseg_pkg.sv
package rmseg_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } segSel_e;

  // strobes from control to datapath
  typedef struct packed {
    segSel_e seg;
    logic    useFetchPtr;
    logic    wrapAt1M;
  } addrCtrl_t;

  localparam logic [2:0] BASE_SP = 3'd4;
  localparam logic [2:0] BASE_BP = 3'd5;
endpackage

// File: rtl/rmAddrCtrl.sv
module rmAddrCtrl
  import rmseg_pkg::*;
(
  input  logic      fetch,
  input  logic      ovrEn,
  input  logic [1:0] ovrSel,
  input  logic [2:0] baseSel,
  input  logic      a20Gate,
  output addrCtrl_t ctl
);
  logic stackBased;
  assign stackBased = (baseSel == BASE_SP) || (baseSel == BASE_BP);

  always_comb begin
    ctl.useFetchPtr = fetch;
    ctl.wrapAt1M    = !a20Gate;
    if (fetch)           ctl.seg = SEG_CODE;
    else if (ovrEn)      ctl.seg = segSel_e'(ovrSel);
    else if (stackBased) ctl.seg = SEG_STACK;
    else                 ctl.seg = SEG_DATA;
  end
endmodule

// File: rtl/rmAddrPath.sv
module rmAddrPath
  import rmseg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int OUT_W = 32,
  parameter logic [SEG_W-1:0] RESET_CS = 16'hF000,
  parameter logic [OFF_W-1:0] RESET_IP = 16'hFFF0
) (
  input  logic             clk,
  input  logic             rst,
  input  addrCtrl_t        ctl,
  input  logic [SEG_W-1:0] codeSeg,
  input  logic [SEG_W-1:0] dataSeg,
  input  logic [SEG_W-1:0] stackSeg,
  input  logic [SEG_W-1:0] extraSeg,
  input  logic [OFF_W-1:0] offset,
  input  logic             ptrLoad,
  output logic [OUT_W-1:0] physAddr
);
  localparam int SUM_W = SEG_W + SHIFT + 1;

  logic [SEG_W-1:0] csHeld;
  logic [OFF_W-1:0] ipHeld;
  logic [SEG_W-1:0] segVal;
  logic [OFF_W-1:0] offVal;
  logic [SUM_W-1:0] rawSum;
  logic [SUM_W-1:0] gatedSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      csHeld <= RESET_CS;
      ipHeld <= RESET_IP;
    end else if (ptrLoad) begin
      csHeld <= codeSeg;
      ipHeld <= offset;
    end
  end

  always_comb begin
    if (ctl.useFetchPtr) segVal = csHeld;
    else begin
      case (ctl.seg)
        SEG_EXTRA: segVal = extraSeg;
        SEG_CODE:  segVal = codeSeg;
        SEG_STACK: segVal = stackSeg;
        default:   segVal = dataSeg;
      endcase
    end
    offVal = ctl.useFetchPtr ? ipHeld : offset;
  end

  assign rawSum = {1'b0, segVal, {SHIFT{1'b0}}} + {{(SUM_W-OFF_W){1'b0}}, offVal};
  assign gatedSum = {rawSum[SUM_W-1] & !ctl.wrapAt1M, rawSum[SUM_W-2:0]};

  generate
    if (OUT_W > SUM_W) begin : g_pad
      assign physAddr = {{(OUT_W-SUM_W){1'b0}}, gatedSum};
    end else begin : g_exact
      assign physAddr = gatedSum[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/rmAddrGen.sv
module rmAddrGen
  import rmseg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int OUT_W = 32,
  parameter logic [SEG_W-1:0] RESET_CS = 16'hF000,
  parameter logic [OFF_W-1:0] RESET_IP = 16'hFFF0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEG_W-1:0] codeSeg,
  input  logic [SEG_W-1:0] dataSeg,
  input  logic [SEG_W-1:0] stackSeg,
  input  logic [SEG_W-1:0] extraSeg,
  input  logic [OFF_W-1:0] offset,
  input  logic [2:0]       baseSel,
  input  logic             ovrEn,
  input  logic [1:0]       ovrSel,
  input  logic             fetch,
  input  logic             ptrLoad,
  input  logic             a20Gate,
  output logic [OUT_W-1:0] physAddr,
  output logic [1:0]       segUsed
);
  addrCtrl_t ctl;

  rmAddrCtrl u_ctrl (
    .fetch   (fetch),
    .ovrEn   (ovrEn),
    .ovrSel  (ovrSel),
    .baseSel (baseSel),
    .a20Gate (a20Gate),
    .ctl     (ctl)
  );

  rmAddrPath #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .OUT_W(OUT_W),
    .RESET_CS(RESET_CS), .RESET_IP(RESET_IP)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .codeSeg  (codeSeg),
    .dataSeg  (dataSeg),
    .stackSeg (stackSeg),
    .extraSeg (extraSeg),
    .offset   (offset),
    .ptrLoad  (ptrLoad),
    .physAddr (physAddr)
  );

  assign segUsed = ctl.seg;
endmodule

// File: rtl/rmAddrGen_chk.sv
module rmAddrGen_chk
  import rmseg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int OUT_W = 32,
  parameter logic [SEG_W-1:0] RESET_CS = 16'hF000,
  parameter logic [OFF_W-1:0] RESET_IP = 16'hFFF0
) (
  input logic             clk,
  input logic             rst,
  input logic [OFF_W-1:0] offset,
  input logic [2:0]       baseSel,
  input logic             ovrEn,
  input logic [1:0]       ovrSel,
  input logic             fetch,
  input logic             ptrLoad,
  input logic             a20Gate,
  input logic [OUT_W-1:0] physAddr,
  input logic [1:0]       segUsed
);
  localparam int SUM_W = SEG_W + SHIFT + 1;
  localparam logic [OUT_W-1:0] FIRST_FETCH =
    OUT_W'({RESET_CS, {SHIFT{1'b0}}}) + OUT_W'(RESET_IP);

  assert_low_bits_R1: assert property (@(posedge clk) disable iff (rst)
    !fetch |-> physAddr[SHIFT-1:0] == offset[SHIFT-1:0]);

  assert_fetch_code_R2: assert property (@(posedge clk) disable iff (rst)
    fetch |-> segUsed == SEG_CODE);

  assert_stack_default_R3: assert property (@(posedge clk) disable iff (rst)
    (!fetch && !ovrEn && (baseSel == 3'd4 || baseSel == 3'd5)) |-> segUsed == SEG_STACK);

  assert_data_default_R4: assert property (@(posedge clk) disable iff (rst)
    (!fetch && !ovrEn && baseSel != 3'd4 && baseSel != 3'd5) |-> segUsed == SEG_DATA);

  assert_override_R5: assert property (@(posedge clk) disable iff (rst)
    (!fetch && ovrEn) |-> segUsed == ovrSel);

  assert_reset_fetch_R6: assert property (@(posedge clk)
    rst |=> (!fetch || physAddr == FIRST_FETCH));

  assert_load_ip_R7: assert property (@(posedge clk) disable iff (rst)
    ptrLoad |=> (!fetch || physAddr[SHIFT-1:0] == $past(offset[SHIFT-1:0])));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    !a20Gate |-> !physAddr[SUM_W-1]);

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    physAddr[OUT_W-1:SUM_W] == '0);
endmodule

bind rmAddrGen rmAddrGen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .OUT_W(OUT_W),
  .RESET_CS(RESET_CS), .RESET_IP(RESET_IP)
) u_chk (.*);

// File: tb/rmAddrGen_tb.sv
`timescale 1ns/1ps
module rmAddrGen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] codeSeg = '0, dataSeg = '0, stackSeg = '0, extraSeg = '0, offset = '0;
  logic [2:0]  baseSel = '0;
  logic        ovrEn = 1'b0;
  logic [1:0]  ovrSel = '0;
  logic        fetch = 1'b1;
  logic        ptrLoad = 1'b0;
  logic        a20Gate = 1'b0;
  logic [31:0] physAddr;
  logic [1:0]  segUsed;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;
  string reqTag = "R6";
  int unsigned mCs = 0, mIp = 0;

  always #5 clk = ~clk;

  rmAddrGen u_dut (
    .clk(clk), .rst(rst), .codeSeg(codeSeg), .dataSeg(dataSeg),
    .stackSeg(stackSeg), .extraSeg(extraSeg), .offset(offset),
    .baseSel(baseSel), .ovrEn(ovrEn), .ovrSel(ovrSel), .fetch(fetch),
    .ptrLoad(ptrLoad), .a20Gate(a20Gate), .physAddr(physAddr), .segUsed(segUsed)
  );

  // reference model of the held fetch pointer
  always @(posedge clk) begin
    started <= 1'b1;
    cycles  <= cycles + 1;
    if (rst) begin
      mCs <= 32'hF000;
      mIp <= 32'hFFF0;
    end else if (ptrLoad) begin
      mCs <= codeSeg;
      mIp <= offset;
    end
  end

  task automatic checkNow();
    int unsigned expSeg, segVal, offVal, expAddr;
    if (fetch) expSeg = 1;
    else if (ovrEn) expSeg = ovrSel;
    else if (baseSel == 4 || baseSel == 5) expSeg = 2;
    else expSeg = 3;
    case (expSeg)
      0: segVal = extraSeg;
      1: segVal = codeSeg;
      2: segVal = stackSeg;
      default: segVal = dataSeg;
    endcase
    if (fetch) segVal = mCs;
    offVal = fetch ? mIp : offset;
    expAddr = segVal * 16 + offVal;
    if (!a20Gate) expAddr = expAddr % 32'h100000;
    checks++;
    if (physAddr !== expAddr || segUsed !== expSeg[1:0]) begin
      errors++;
      $display("FAIL %s: addr %h seg %0d, expected addr %h seg %0d",
               reqTag, physAddr, segUsed, expAddr, expSeg);
    end
  endtask

  always @(negedge clk) if (started && !done) checkNow();

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R6: reset with fetch asserted
    reqTag = "R6";
    tick(); tick();
    // R6: reset wins over ptrLoad
    ptrLoad = 1'b1; codeSeg = 16'h1111; offset = 16'h2222;
    tick();
    ptrLoad = 1'b0;
    tick();
    rst = 1'b0;
    // R2: fetch ignores override, base and offset
    reqTag = "R2";
    ovrEn = 1'b1; ovrSel = 2'd0; baseSel = 3'd4; offset = 16'h1357; extraSeg = 16'h4444;
    tick();
    ovrEn = 1'b0;
    tick();
    // R3 and R1: stack defaults
    fetch = 1'b0;
    reqTag = "R3";
    stackSeg = 16'h1234; offset = 16'h5678; baseSel = 3'd4; dataSeg = 16'h9999;
    tick();
    stackSeg = 16'h8110; offset = 16'h091C; baseSel = 3'd5;
    tick();
    // R4 and R1: data defaults over all other base codes
    reqTag = "R4";
    dataSeg = 16'h8000; offset = 16'h1A1C;
    for (int b = 0; b < 8; b++) begin
      if (b != 4 && b != 5) begin
        baseSel = 3'(b);
        tick();
      end
    end
    reqTag = "R1";
    dataSeg = 16'hFFFF; offset = 16'h0000; baseSel = 3'd3;
    tick();
    dataSeg = 16'h168A; offset = 16'h1118;
    tick();
    // R5: each override code
    reqTag = "R5";
    codeSeg = 16'h168A; dataSeg = 16'h1000; stackSeg = 16'h3000; extraSeg = 16'h0400;
    offset = 16'h1118; baseSel = 3'd4; ovrEn = 1'b1;
    for (int s = 0; s < 4; s++) begin
      ovrSel = 2'(s);
      tick();
    end
    ovrEn = 1'b0;
    // R8 / R9 / R10: carry into bit 20
    reqTag = "R8";
    dataSeg = 16'hF400; offset = 16'hE000; baseSel = 3'd6; a20Gate = 1'b0;
    tick();
    reqTag = "R9";
    a20Gate = 1'b1;
    tick();
    reqTag = "R10";
    dataSeg = 16'hFFFF; offset = 16'hFFFF;
    tick();
    a20Gate = 1'b0;
    // R7: far load then fetch
    reqTag = "R7";
    codeSeg = 16'h0400; offset = 16'h0128; ptrLoad = 1'b1;
    tick();
    ptrLoad = 1'b0; fetch = 1'b1; codeSeg = 16'h7777; offset = 16'h0000;
    tick();
    codeSeg = 16'hFFFF; offset = 16'hFFF0; ptrLoad = 1'b1;
    tick();
    ptrLoad = 1'b0;
    reqTag = "R8";
    tick();
    reqTag = "R9";
    a20Gate = 1'b1;
    tick();
    // R11: mid-cycle change, no edge between
    reqTag = "R11";
    fetch = 1'b0; ovrEn = 1'b0; baseSel = 3'd2; dataSeg = 16'h2000; offset = 16'h0010;
    @(negedge clk);
    #1;
    offset = 16'h0020;
    #1;
    checkNow();
    tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 2000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: cycles %0d, expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule